// File: doc/BRIEF.md
# Pin Edge Event and Interrupt Controller

The block watches a bank of input pins, brings each one into the clock domain through a two-stage synchronizer and looks for transitions on it. Every pin has a two-bit sensitivity field that selects which transitions matter: none, rising, falling or both. A matching transition latches a sticky bit in the event register. If the pin is also enabled in the interrupt-enable register, a bit in the pending-interrupt register is latched as well. An active-low interrupt line stays asserted while any pending-interrupt bit is set.

Software clears bits by writing ones. The event and pending registers share the clear: writing a one into either register clears the same pin's bit in both. A mode bit lets a read of the pin-level register also clear all pending-interrupt bits. Rewriting a pin's sensitivity field with a different value drops that pin's recorded bits. The host reaches the registers through single-cycle write and read strobes.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset, the event, pending, enable, sensitivity and mode registers all read 0, and `irq_n` is 1.
- R2: Sensitivity encoding per pin: 00 none, 01 rising, 10 falling, 11 both. Pin i's field sits at bits [2i+1:2i] of the low sensitivity register (address 2) for pins below NPINS/2. For the other pins it sits at bits [2(i-NPINS/2)+1:2(i-NPINS/2)] of the high register (address 3).
- R3: A selected transition sets the pin's event bit (address 4). The bit appears 3 clock edges after the pin changes and stays 1 until it is cleared.
- R4: A transition also sets the pin's pending bit (address 5), but only when the pin's enable bit (address 1, 1 = enabled) is 1.
- R5: Writing 1 to a bit of the pending register clears that bit and the same pin's event bit. Bits written with 0 are unchanged.
- R6: Writing 1 to a bit of the event register clears that bit and the same pin's pending bit.
- R7: `irq_n` is 0 while any pending bit is 1. It returns to 1 only when all pending bits are 0.
- R8: Writing a pin's sensitivity field with a value that differs from its current value clears that pin's event and pending bits. Writing the same value leaves them unchanged.
- R9: Mode register bit 0 (address 6) selects the clear mode. At 0, a read of the pin-level register (address 0) clears every pending bit and leaves the event bits unchanged. At 1, such a read clears nothing.
- R10: When a transition is detected in the same cycle as a clear of that pin's bit, the bit ends up set.
- R11: Address 0 reads the synchronized pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Asynchronous input pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data for `addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default of eight pins. With eight pins, the sensitivity fields are split across two registers, so both the low-half and the high-half field decoding are exercised. The bench also places a clear write in exactly the cycle in which a detected edge lands, which tests the set-over-clear priority.

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  output logic             irq_n
);
  localparam int HALF = NPINS / 2;
  localparam logic [2:0] A_DATA = 3'd0, A_EN = 3'd1, A_SLO = 3'd2, A_SHI = 3'd3,
                         A_EVT = 3'd4, A_PND = 3'd5, A_MODE = 3'd6;

  logic [NPINS-1:0]   s1_q, s2_q, prev_q;
  logic [NPINS-1:0]   en_q, evt_q, pnd_q;
  logic [2*NPINS-1:0] sens_q;
  logic               manual_q;
  logic [NPINS-1:0]   hit, sens_clr;

  wire [NPINS-1:0] rise = s2_q & ~prev_q;
  wire [NPINS-1:0] fall = ~s2_q & prev_q;
  wire w1c_hit  = wr_en && (addr == A_EVT || addr == A_PND);
  wire auto_clr = rd_en && addr == A_DATA && !manual_q;
  wire [NPINS-1:0] clr_both = (w1c_hit ? wdata : '0) | sens_clr;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int SLOT = (i < HALF) ? i : i - HALF;
    wire [1:0] fld = sens_q[2*i +: 2];
    wire       sel = wr_en && (addr == ((i < HALF) ? A_SLO : A_SHI));
    assign hit[i]      = (fld[0] & rise[i]) | (fld[1] & fall[i]);
    assign sens_clr[i] = sel && (wdata[2*SLOT +: 2] != fld);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; prev_q <= '0;
      en_q <= '0; evt_q <= '0; pnd_q <= '0;
      sens_q <= '0; manual_q <= 1'b0;
    end else begin
      s1_q   <= pins_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      evt_q  <= (evt_q & ~clr_both) | hit;
      pnd_q  <= (pnd_q & ~clr_both & {NPINS{!auto_clr}}) | (hit & en_q);
      if (wr_en) begin
        case (addr)
          A_EN:   en_q <= wdata;
          A_SLO:  sens_q[NPINS-1:0] <= wdata;
          A_SHI:  sens_q[2*NPINS-1:NPINS] <= wdata;
          A_MODE: manual_q <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DATA: rdata = s2_q;
      A_EN:   rdata = en_q;
      A_SLO:  rdata = sens_q[NPINS-1:0];
      A_SHI:  rdata = sens_q[2*NPINS-1:NPINS];
      A_EVT:  rdata = evt_q;
      A_PND:  rdata = pnd_q;
      A_MODE: rdata = {{(NPINS-1){1'b0}}, manual_q};
      default: rdata = '0;
    endcase
  end

  assign irq_n = ~|pnd_q;

  AST_EVT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~$past(evt_q) & ~$past(hit)) == '0);  // R3
  AST_PND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (pnd_q & ~$past(pnd_q) & ~$past(en_q)) == '0);  // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_hit |=> (evt_q & $past(wdata) & ~$past(hit)) == '0);  // R5
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(wr_en || rd_en));  // R7
  AST_PND_IN_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (pnd_q & ~evt_q) == '0);  // R6
endmodule

// File: tb/gpio_evt_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_evt_irq_tb_top;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [N-1:0] pins = '0, wdata = '0, rdata;
  logic [2:0] addr = '0;
  logic irq_n;
  int n_chk = 0, n_bad = 0;

  gpio_evt_irq #(.NPINS(N)) dut_i (.clk(clk), .rst_n(rst_n), .pins_i(pins),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic drive(input logic [N-1:0] p);
    @(negedge clk); pins = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    chk("R1 irq_n", int'(irq_n), 1);
    for (int a = 1; a <= 6; a++) begin
      rd(3'(a), v); chk("R1 reg", int'(v), 0);
    end
  endtask

  task automatic t_rise;
    logic [N-1:0] v;
    wr(3'd2, 8'h01); wr(3'd1, 8'h01);
    drive(8'h01);
    rd(3'd4, v); chk("R3 rise evt", int'(v), 8'h01);
    rd(3'd5, v); chk("R4 rise pnd", int'(v), 8'h01);
    chk("R7 irq low", int'(irq_n), 0);
    rd(3'd0, v); chk("R11 levels", int'(v), 8'h01);
    wr(3'd4, 8'h01);
    drive(8'h00);
    rd(3'd4, v); chk("R2 falling ignored by rising", int'(v), 0);
  endtask

  task automatic t_fall_unmasked;
    logic [N-1:0] v;
    wr(3'd2, 8'h08);
    drive(8'h02); drive(8'h00);
    rd(3'd4, v); chk("R2 fall evt", int'(v), 8'h02);
    rd(3'd5, v); chk("R4 unmasked no pnd", int'(v), 0);
    chk("R4 irq high", int'(irq_n), 1);
    wr(3'd4, 8'h02);
  endtask

  task automatic t_both_none;
    logic [N-1:0] v;
    wr(3'd3, 8'h0C);
    drive(8'h20);
    rd(3'd4, v); chk("R2 both rise pin5", int'(v), 8'h20);
    wr(3'd4, 8'h20);
    drive(8'h00);
    rd(3'd4, v); chk("R2 both fall pin5", int'(v), 8'h20);
    wr(3'd4, 8'h20);
    drive(8'h04); drive(8'h00);
    rd(3'd4, v); chk("R2 none pin2", int'(v), 0);
  endtask

  task automatic t_w1c;
    logic [N-1:0] v;
    wr(3'd1, 8'h21); wr(3'd2, 8'h01);
    drive(8'h21);
    rd(3'd5, v); chk("R4 two pnd", int'(v), 8'h21);
    wr(3'd5, 8'h01);
    rd(3'd4, v); chk("R5 evt follows pnd clr", int'(v), 8'h20);
    chk("R7 irq still low", int'(irq_n), 0);
    wr(3'd4, 8'h20);
    rd(3'd5, v); chk("R6 pnd follows evt clr", int'(v), 0);
    chk("R7 irq released", int'(irq_n), 1);
    drive(8'h00); wr(3'd4, 8'hFF);
  endtask

  task automatic t_sense_change;
    logic [N-1:0] v;
    drive(8'h01);
    wr(3'd2, 8'h01);
    rd(3'd4, v); chk("R8 same value keeps", int'(v), 8'h01);
    wr(3'd2, 8'h03);
    rd(3'd4, v); chk("R8 change clears evt", int'(v), 0);
    rd(3'd5, v); chk("R8 change clears pnd", int'(v), 0);
    drive(8'h00); wr(3'd4, 8'hFF);
  endtask

  task automatic t_autoclr;
    logic [N-1:0] v;
    drive(8'h01);
    rd(3'd0, v);
    rd(3'd5, v); chk("R9 auto clear pnd", int'(v), 0);
    rd(3'd4, v); chk("R9 evt kept", int'(v), 8'h01);
    wr(3'd4, 8'hFF); wr(3'd6, 8'h01);
    drive(8'h00);
    rd(3'd0, v);
    rd(3'd5, v); chk("R9 manual keeps pnd", int'(v), 8'h01);
    wr(3'd5, 8'hFF);
  endtask

  task automatic t_collide;
    logic [N-1:0] v;
    @(negedge clk); pins = 8'h01;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 3'd4; wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    rd(3'd4, v); chk("R10 set wins evt", int'(v), 8'h01);
    rd(3'd5, v); chk("R10 set wins pnd", int'(v), 8'h01);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_rise; t_fall_unmasked; t_both_none;
    t_w1c; t_sense_change; t_autoclr; t_collide;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule